// File: doc/BRIEF.md
# Fractional M/N:D Clock Divider

This block derives a slower clock from its input clock so that, over any run of N input cycles, the output shows exactly M rising edges. A third value, D, sets how many of those input cycles the output spends high. Software hands the block its three values in a stored encoding. M is written as is, N is written as the inverse of (N minus M), and D is written as its own inverse. The block decodes these values, clamps D into a safe band, and runs a phase accumulator that adds M every input cycle and wraps modulo N.

A two-bit mode field selects the fractional path or the pass-through path. A configuration that cannot produce a real fraction falls back to pass-through, in which the input clock appears at the output unchanged. When the M/N width parameter is zero, the stage is absent and is always pass-through. A one-cycle load strobe presents a new configuration. When the block is in pass-through it takes the configuration on the next edge. When the fractional path is running, it holds the configuration until the next accumulator wrap, so the output never shows a runt pulse.

The controller has three states. ST_BYPASS forwards the input clock. ST_RUN runs the accumulator. ST_PEND runs the accumulator while a new configuration waits. The transitions are:
- BYPASS_TO_RUN: a load with a valid fraction while in bypass.
- RUN_TO_PEND: a load while running.
- PEND_TO_PEND: a further load before the wrap, which replaces the waiting configuration.
- PEND_APPLY: at a wrap, the waiting configuration is applied, and the state goes to ST_RUN or ST_BYPASS depending on whether that configuration is a valid fraction.

Top module: `mnd_frac_div`

## Requirements
- R1: The decoded values are M = m_code, N = (~n_code + M) modulo 2^MN_W, and D = ~d_code, all MN_W bits wide.
- R2: The fractional path is selected only when mode is 2'b10, M is nonzero and 2·M ≤ N. Every other mode value (2'b00, 2'b01, 2'b11) and every other M/N pair gives pass-through.
- R3: In pass-through, clk_out follows clk, being high in the high half of each input cycle and low in the low half. This also holds during and straight after reset.
- R4: On the fractional path, clk_out is registered and constant within each input cycle. Any N consecutive cycles contain exactly M cycles in which clk_out rises from the previous cycle.
- R5: D is clamped into the band [M, N−M], so that D = 0 and D ≥ N are usable. On the fractional path, every window of N cycles contains both high and low cycles.
- R6: With the clamped value Dc and g = gcd(M, N), any N consecutive fractional cycles contain exactly g·ceil(Dc/g) high cycles.
- R7: A load taken in pass-through applies on the next clock edge. A valid fraction starts with a high output cycle and a zeroed accumulator.
- R8: A load taken while the fractional path runs is held back until the next accumulator wrap. The switch appears in the cycle of that wrap, and the preceding cycle is low. A later load before the wrap replaces the waiting configuration.
- R9: With MN_W = 0, clk_out is clk at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_code | input | max(MN_W,1) | M as stored |
| n_code | input | max(MN_W,1) | Inverse of (N − M) |
| d_code | input | max(MN_W,1) | Inverse of the D threshold |
| mode | input | 2 | 2'b10 selects the fractional path; other values select pass-through |
| load | input | 1 | One-cycle strobe that presents the configuration inputs |
| clk_out | output | 1 | Divided clock, or clk in pass-through |

## Verification
The assertions take for granted that a fractional configuration has 2·M ≤ N. The decoder enforces this by rejecting other pairs, so the accumulator and the clamp band always stay in range. The assertions also take for granted that configuration inputs only matter in the cycle where load is high. The stimulus keeps to this by building each random N in 2..255 and drawing M from 1..N/2 before encoding them, while D is drawn over the full range so that the clamp is exercised. Directed cases add forbidden mode values, an over-half ratio and deferred loads. The bench changes inputs only in the low half of the clock.

// File: rtl/mnd_pkg.sv
package mnd_pkg;

    localparam logic [1:0] MODE_DUAL = 2'b10;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'b00,
        ST_RUN    = 2'b01,
        ST_PEND   = 2'b10
    } mnd_state_e;

endpackage

// File: rtl/mnd_decode.sv
module mnd_decode #(
    parameter int W = 8
) (
    input  logic [W-1:0] m_code,
    input  logic [W-1:0] n_code,
    input  logic [W-1:0] d_code,
    input  logic [1:0]   mode,
    output logic         cfg_valid,
    output logic [W-1:0] cfg_m,
    output logic [W-1:0] cfg_n,
    output logic [W-1:0] cfg_d
);
    import mnd_pkg::*;

    logic [W:0]   two_m;
    logic [W-1:0] d_raw;
    logic [W-1:0] d_hi;

    always_comb begin
        cfg_m     = m_code;
        cfg_n     = W'(~n_code + m_code);
        d_raw     = ~d_code;
        two_m     = {m_code, 1'b0};
        cfg_valid = (mode == MODE_DUAL) && (m_code != '0) && (two_m <= {1'b0, cfg_n});
        d_hi      = cfg_n - cfg_m;
        if (d_raw < cfg_m)
            cfg_d = cfg_m;
        else if (d_raw > d_hi)
            cfg_d = d_hi;
        else
            cfg_d = d_raw;
    end

endmodule

// File: rtl/mnd_ctrl.sv
module mnd_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         cfg_valid,
    input  logic [W-1:0] cfg_m,
    input  logic [W-1:0] cfg_n,
    input  logic [W-1:0] cfg_d,
    output logic         frac_out,
    output logic         bypass
);
    import mnd_pkg::*;

    mnd_state_e   state_q, state_d;
    logic [W-1:0] m_q, n_q, d_q, acc_q;
    logic [W-1:0] sh_m, sh_n, sh_d;
    logic         sh_v;
    logic         frac_q;
    logic [W:0]   acc_sum;
    logic         wrap;
    logic [W-1:0] acc_nxt;
    logic         apply_new, apply_sh, capture;
    logic         sel_v;
    logic [W-1:0] sel_m, sel_n, sel_d;

    always_comb begin
        acc_sum   = {1'b0, acc_q} + {1'b0, m_q};
        wrap      = acc_sum >= {1'b0, n_q};
        acc_nxt   = wrap ? W'(acc_sum - {1'b0, n_q}) : acc_sum[W-1:0];
        apply_new = load && ((state_q == ST_BYPASS) || (state_q == ST_PEND && wrap));
        apply_sh  = (state_q == ST_PEND) && wrap && !load;
        capture   = load && ((state_q == ST_RUN) || (state_q == ST_PEND && !wrap));
        sel_v     = apply_new ? cfg_valid : sh_v;
        sel_m     = apply_new ? cfg_m : sh_m;
        sel_n     = apply_new ? cfg_n : sh_n;
        sel_d     = apply_new ? cfg_d : sh_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: if (load) state_d = cfg_valid ? ST_RUN : ST_BYPASS;
            ST_RUN:    if (load) state_d = ST_PEND;
            ST_PEND:   if (wrap) state_d = sel_v ? ST_RUN : ST_BYPASS;
            default:   state_d = ST_BYPASS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q    <= '0;
            n_q    <= '0;
            d_q    <= '0;
            acc_q  <= '0;
            frac_q <= 1'b0;
            sh_m   <= '0;
            sh_n   <= '0;
            sh_d   <= '0;
            sh_v   <= 1'b0;
        end else begin
            if (apply_new || apply_sh) begin
                m_q    <= sel_m;
                n_q    <= sel_n;
                d_q    <= sel_d;
                acc_q  <= '0;
                frac_q <= sel_v;
            end else if (state_q != ST_BYPASS) begin
                acc_q  <= acc_nxt;
                frac_q <= acc_nxt < d_q;
            end
            if (capture) begin
                sh_m <= cfg_m;
                sh_n <= cfg_n;
                sh_d <= cfg_d;
                sh_v <= cfg_valid;
            end
        end
    end

    assign frac_out = frac_q;
    assign bypass   = (state_q == ST_BYPASS);

    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BYPASS) |-> (acc_q < n_q)); // R4
    AST_D_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BYPASS) |-> (d_q >= m_q && d_q <= n_q - m_q)); // R5
    AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BYPASS && $rose(frac_q)) |-> (acc_q < m_q)); // R4
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !wrap) |=> ($stable(m_q) && $stable(n_q) && $stable(d_q))); // R8
    AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS) |-> !frac_q); // R3
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS && load && cfg_valid) |=> (frac_q && acc_q == '0)); // R7

endmodule

// File: rtl/mnd_frac_div.sv
module mnd_frac_div #(
    parameter int MN_W = 8,
    localparam int PW  = (MN_W > 0) ? MN_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] m_code,
    input  logic [PW-1:0] n_code,
    input  logic [PW-1:0] d_code,
    input  logic [1:0]    mode,
    input  logic          load,
    output logic          clk_out
);
    generate
        if (MN_W == 0) begin : g_absent
            assign clk_out = clk;
        end else begin : g_stage
            logic          cfg_valid;
            logic [PW-1:0] cfg_m, cfg_n, cfg_d;
            logic          frac_out, bypass;

            mnd_decode #(.W(PW)) i_decode (
                .m_code   (m_code),
                .n_code   (n_code),
                .d_code   (d_code),
                .mode     (mode),
                .cfg_valid(cfg_valid),
                .cfg_m    (cfg_m),
                .cfg_n    (cfg_n),
                .cfg_d    (cfg_d)
            );

            mnd_ctrl #(.W(PW)) i_ctrl (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load),
                .cfg_valid(cfg_valid),
                .cfg_m    (cfg_m),
                .cfg_n    (cfg_n),
                .cfg_d    (cfg_d),
                .frac_out (frac_out),
                .bypass   (bypass)
            );

            assign clk_out = bypass ? clk : frac_out;
        end
    endgenerate

endmodule

// File: tb/test_mnd_frac_div.sv
module test_mnd_frac_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_code = '0, n_code = '0, d_code = '0;
    logic [1:0] mode = 2'b00;
    logic       load = 1'b0;
    logic       clk_out, clk_out_w0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mnd_frac_div #(.MN_W(8)) i_mnd_frac_div (
        .clk(clk), .rst_n(rst_n), .m_code(m_code), .n_code(n_code),
        .d_code(d_code), .mode(mode), .load(load), .clk_out(clk_out));

    mnd_frac_div #(.MN_W(0)) i_mnd_frac_div_w0 (
        .clk(clk), .rst_n(rst_n), .m_code(1'b0), .n_code(1'b0),
        .d_code(1'b0), .mode(2'b00), .load(1'b0), .clk_out(clk_out_w0));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    logic hi_s, lo_s, prev_s;

    task automatic step();
        @(posedge clk); #5 hi_s = clk_out;
        @(negedge clk); #5 lo_s = clk_out;
    endtask

    function automatic int gcd(input int a, input int b);
        int x = a, y = b;
        while (y != 0) begin int t = x % y; x = y; y = t; end
        return x;
    endfunction

    function automatic int clamp_d(input int m, input int n, input int d);
        if (d < m) return m;
        if (d > n - m) return n - m;
        return d;
    endfunction

    function automatic int exp_high(input int m, input int n, input int d);
        int g = gcd(m, n);
        int dc = clamp_d(m, n, d);
        return g * ((dc + g - 1) / g);
    endfunction

    task automatic drive_cfg(input int m, input int n, input int d, input logic [1:0] md);
        m_code = 8'(m);
        n_code = ~8'(n - m);
        d_code = ~8'(d);
        mode   = md;
        load   = 1'b1;
        step();
        load   = 1'b0;
    endtask

    task automatic measure(input int n, output int rises, output int highs, output int pass_cyc);
        rises = 0; highs = 0; pass_cyc = 0;
        step(); prev_s = hi_s;
        for (int i = 0; i < n; i++) begin
            step();
            if (hi_s && !lo_s) pass_cyc++;
            if (hi_s && !prev_s) rises++;
            if (hi_s) highs++;
            prev_s = hi_s;
        end
    endtask

    task automatic run_frac(input int m, input int n, input int d, input string tag);
        int r, h, p;
        drive_cfg(m, n, d, 2'b10);
        repeat (2 * n + 4) step();
        measure(n, r, h, p);
        chk(p == 0, {tag, " R2 fractional selected"}, p, 0);
        chk(r == m, {tag, " R4 rises per N"}, r, m);
        chk(h == exp_high(m, n, d), {tag, " R6 high cycles per N"}, h, exp_high(m, n, d));
        chk(h > 0 && h < n, {tag, " R5 not constant"}, h, clamp_d(m, n, d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_init;
        int r, h, p, k, pre;
        seed_init = $urandom(32'd4242);
        // R3: pass-through during reset
        @(posedge clk); #5 hi_s = clk_out;
        @(negedge clk); #5 lo_s = clk_out;
        chk(hi_s == 1'b1 && lo_s == 1'b0, "R3 reset pass-through", {hi_s, lo_s}, 2);
        rst_n = 1'b1;
        step();
        chk(hi_s == 1'b1 && lo_s == 1'b0, "R3 after reset", {hi_s, lo_s}, 2);
        chk(clk_out_w0 == clk, "R9 absent stage low", clk_out_w0, clk);
        @(posedge clk); #5 chk(clk_out_w0 == 1'b1, "R9 absent stage high", clk_out_w0, 1);
        @(negedge clk); #5;

        // R7: load in bypass applies at once and starts high
        drive_cfg(3, 10, 4, 2'b10);
        chk(hi_s == 1'b1 && lo_s == 1'b1, "R7 first cycle high", {hi_s, lo_s}, 3);
        repeat (24) step();
        measure(10, r, h, p);
        chk(r == 3, "R4 3/10 rises", r, 3);
        chk(h == exp_high(3, 10, 4), "R6 3/10 highs", h, exp_high(3, 10, 4));

        // R1 R5 directed clamps: D=0 and D>=N
        run_frac(1, 7, 0, "R1 d=0");
        run_frac(2, 9, 200, "R1 d=200");
        run_frac(5, 10, 5, "R1 half ratio");
        run_frac(1, 255, 128, "R1 max n");

        // R8: deferred load while running (m=1 n=10 d=5)
        drive_cfg(1, 10, 5, 2'b10);
        repeat (25) step();
        prev_s = hi_s;
        step();
        while (!(hi_s && !prev_s)) begin prev_s = hi_s; step(); end
        step(); step();
        m_code = 8'd1; n_code = ~8'd9; d_code = ~8'd5; mode = 2'b00; load = 1'b1;
        pre = hi_s;
        k = 0;
        for (int i = 1; i <= 12; i++) begin
            step();
            load = 1'b0;
            if (k == 0 && hi_s && !lo_s) begin
                k = i;
                chk(pre == 0, "R8 preceding cycle low", pre, 0);
            end
            if (k == 0) pre = hi_s;
        end
        chk(k == 8, "R8 switch at wrap", k, 8);

        // R8: second load before wrap replaces the waiting one
        drive_cfg(1, 10, 5, 2'b10);
        repeat (25) step();
        drive_cfg(1, 10, 5, 2'b00);
        drive_cfg(1, 4, 2, 2'b10);
        repeat (30) step();
        measure(4, r, h, p);
        chk(r == 1 && h == 2 && p == 0, "R8 latest load wins", r * 10 + h, 12);

        // R2: forbidden mode values and an over-half ratio
        drive_cfg(1, 1, 1, 2'b00);
        repeat (12) step();
        drive_cfg(2, 8, 3, 2'b11);
        chk(hi_s && !lo_s, "R2 mode 11 pass-through", {hi_s, lo_s}, 2);
        drive_cfg(2, 8, 3, 2'b01);
        chk(hi_s && !lo_s, "R2 mode 01 pass-through", {hi_s, lo_s}, 2);
        drive_cfg(5, 8, 3, 2'b10);
        chk(hi_s && !lo_s, "R2 over-half pass-through", {hi_s, lo_s}, 2);
        drive_cfg(4, 4, 3, 2'b10);
        chk(hi_s && !lo_s, "R2 M equals N pass-through", {hi_s, lo_s}, 2);

        // random ratios (R4 R5 R6)
        for (int t = 0; t < 16; t++) begin
            int n = 2 + int'($urandom % 254);
            int m = 1 + int'($urandom % (n / 2));
            int d = int'($urandom % 256);
            run_frac(m, n, d, "rand");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule